// File: doc/BRIEF.md
# Converter Power-Up Configuration Sequencer

This block takes a multi-channel data converter from power-up to a calibrated state in which it streams data. After a start request it waits out the power-on delay. It then pulses the converter's active-high reset pin and waits for the reset to settle. Next it plays a fixed program of paged register writes toward an external serial-bus master. Every group of writes starts with a three-write page select. A calibration enable/disable pair is separated by a long timed wait. The program ends by turning off the converter's timing-reference input. A done flag then rises.

The program sits in an internal constant table. Each entry is one of five operations: write, write only in interleaved mode, timed wait, reset pulse, or end. A mode input is sampled at start and selects one of two variants. The plain variant runs single ADCs. The interleaved variant runs 2x interleaved pairs with averaging. Wait lengths are given in microseconds and scaled by a cycles-per-microsecond parameter.

Writes leave through a valid/ready port. The sequencer raises `wr_valid` with an address and data byte. It holds all three unchanged until the master returns `wr_ready`. The write counts as done on the clock edge where both are high. The master may hold `wr_ready` low for as long as it needs, and the sequence simply stalls. `wr_ready` has no effect while `wr_valid` is low.

Top module: `cfg_seq_top`

## Requirements
- R1: While `rst_n` is low and after its release, `wr_valid`, `conv_reset` and `done` are 0 until a start is taken.
- R2: After start, `conv_reset` stays low for at least PWRUP_US*CYC_PER_US cycles. It is then high for at least RST_PULSE_CYC cycles, then low again. `wr_valid` is never high while `conv_reset` is high.
- R3: The first `wr_valid` comes no earlier than POSTRST_US*CYC_PER_US cycles after `conv_reset` falls.
- R4: The plain variant writes these (address=data) pairs in this order. 00=81. Then 11=00 12=01 13=00, then AB=01 AC=01 AD=08 AE=08 64=02. Then 11=00 12=60 13=00, then 26=0F 20=80. Then 11=FF 12=00 13=00, then D5=08 D5=00 2A=00 CF=50. Then 11=00 12=1E 13=00, then 2D=02. Then 11=00 12=01 13=00, then 8C=02 B7=01 B7=00. Then 11=00 12=00 13=01, then 6A=02. That is 35 writes.
- R5: The interleaved variant (`interleave`=1 at start) inserts A5=03 and A6=20 right after the first page select, and writes AB and AC as 03. That is 37 writes.
- R6: After D5=08 is accepted, D5=00 is not offered for at least CAL_US*CYC_PER_US cycles.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold. After a handshake, `wr_valid` is low for at least the next cycle.
- R8: `done` rises after the final write 6A=02 is accepted. It stays high, with `wr_valid` and `conv_reset` low, until the next start. A start taken while done clears `done` on that edge and reruns the program.
- R9: A start while the program runs has no effect. The variant and the write list do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the program (taken when idle) |
| interleave | input | 1 | Variant select, sampled with start: 1 = interleaved |
| conv_reset | output | 1 | Active-high reset pin to the converter |
| wr_valid | output | 1 | Register write request |
| wr_addr | output | 8 | Register address |
| wr_data | output | 8 | Register data |
| wr_ready | input | 1 | Master accepts the write |
| done | output | 1 | Program complete |

## Verification
A wrong program counter or a bad table entry shows at the write port on the very next request. The address or data breaks the expected order, or the write count at `done` is off. The bench compares every accepted pair against a list it builds from the mode. A timer that is loaded wrongly shows as a reset pulse or an idle gap of the wrong length, measured in cycles against the scaled wait. A state machine that drops or repeats a write under back-pressure shows as changing request fields while `wr_ready` is low, or as a shifted list. Varying ready delays expose this within a few writes.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  localparam int ROM_LEN = 42;
  localparam int PCW     = $clog2(ROM_LEN);

  typedef enum logic [2:0] {
    OP_WR    = 3'd0,
    OP_WRI   = 3'd1,
    OP_WAIT  = 3'd2,
    OP_PULSE = 3'd3,
    OP_END   = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_EXEC, S_WR, S_WAIT, S_PULSE
  } state_e;

  // wait selectors, carried in the address field of an OP_WAIT entry
  localparam logic [7:0] WSEL_PWR = 8'd0;
  localparam logic [7:0] WSEL_RST = 8'd1;
  localparam logic [7:0] WSEL_CAL = 8'd2;

  typedef struct packed {
    op_e        op;
    logic [7:0] addr;
    logic [7:0] d_plain;
    logic [7:0] d_ilv;
  } entry_t;

  function automatic entry_t mk(op_e o, logic [7:0] a, logic [7:0] dp, logic [7:0] di);
    entry_t e;
    e.op = o; e.addr = a; e.d_plain = dp; e.d_ilv = di;
    return e;
  endfunction

  function automatic entry_t rom_entry(logic [PCW-1:0] idx);
    case (idx)
      6'd0:  return mk(OP_WAIT,  WSEL_PWR, 8'h00, 8'h00);
      6'd1:  return mk(OP_PULSE, 8'h00, 8'h00, 8'h00);
      6'd2:  return mk(OP_WAIT,  WSEL_RST, 8'h00, 8'h00);
      6'd3:  return mk(OP_WR,  8'h00, 8'h81, 8'h81);
      6'd4:  return mk(OP_WR,  8'h11, 8'h00, 8'h00);
      6'd5:  return mk(OP_WR,  8'h12, 8'h01, 8'h01);
      6'd6:  return mk(OP_WR,  8'h13, 8'h00, 8'h00);
      6'd7:  return mk(OP_WRI, 8'hA5, 8'h03, 8'h03);
      6'd8:  return mk(OP_WRI, 8'hA6, 8'h20, 8'h20);
      6'd9:  return mk(OP_WR,  8'hAB, 8'h01, 8'h03);
      6'd10: return mk(OP_WR,  8'hAC, 8'h01, 8'h03);
      6'd11: return mk(OP_WR,  8'hAD, 8'h08, 8'h08);
      6'd12: return mk(OP_WR,  8'hAE, 8'h08, 8'h08);
      6'd13: return mk(OP_WR,  8'h64, 8'h02, 8'h02);
      6'd14: return mk(OP_WR,  8'h11, 8'h00, 8'h00);
      6'd15: return mk(OP_WR,  8'h12, 8'h60, 8'h60);
      6'd16: return mk(OP_WR,  8'h13, 8'h00, 8'h00);
      6'd17: return mk(OP_WR,  8'h26, 8'h0F, 8'h0F);
      6'd18: return mk(OP_WR,  8'h20, 8'h80, 8'h80);
      6'd19: return mk(OP_WR,  8'h11, 8'hFF, 8'hFF);
      6'd20: return mk(OP_WR,  8'h12, 8'h00, 8'h00);
      6'd21: return mk(OP_WR,  8'h13, 8'h00, 8'h00);
      6'd22: return mk(OP_WR,  8'hD5, 8'h08, 8'h08);
      6'd23: return mk(OP_WAIT, WSEL_CAL, 8'h00, 8'h00);
      6'd24: return mk(OP_WR,  8'hD5, 8'h00, 8'h00);
      6'd25: return mk(OP_WR,  8'h2A, 8'h00, 8'h00);
      6'd26: return mk(OP_WR,  8'hCF, 8'h50, 8'h50);
      6'd27: return mk(OP_WR,  8'h11, 8'h00, 8'h00);
      6'd28: return mk(OP_WR,  8'h12, 8'h1E, 8'h1E);
      6'd29: return mk(OP_WR,  8'h13, 8'h00, 8'h00);
      6'd30: return mk(OP_WR,  8'h2D, 8'h02, 8'h02);
      6'd31: return mk(OP_WR,  8'h11, 8'h00, 8'h00);
      6'd32: return mk(OP_WR,  8'h12, 8'h01, 8'h01);
      6'd33: return mk(OP_WR,  8'h13, 8'h00, 8'h00);
      6'd34: return mk(OP_WR,  8'h8C, 8'h02, 8'h02);
      6'd35: return mk(OP_WR,  8'hB7, 8'h01, 8'h01);
      6'd36: return mk(OP_WR,  8'hB7, 8'h00, 8'h00);
      6'd37: return mk(OP_WR,  8'h11, 8'h00, 8'h00);
      6'd38: return mk(OP_WR,  8'h12, 8'h00, 8'h00);
      6'd39: return mk(OP_WR,  8'h13, 8'h01, 8'h01);
      6'd40: return mk(OP_WR,  8'h6A, 8'h02, 8'h02);
      default: return mk(OP_END, 8'h00, 8'h00, 8'h00);
    endcase
  endfunction

endpackage

// File: rtl/cfg_seq_rom.sv
module cfg_seq_rom
  import cfg_seq_pkg::*;
(
  input  logic [PCW-1:0] pc,
  output entry_t         entry
);
  always_comb entry = rom_entry(pc);
endmodule

// File: rtl/cfg_seq_timer.sv
module cfg_seq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int CYC_PER_US    = 125,
  parameter int PWRUP_US      = 1000,
  parameter int POSTRST_US    = 100,
  parameter int CAL_US        = 2000,
  parameter int RST_PULSE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       interleave,
  output logic       conv_reset,
  output logic       wr_valid,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  input  logic       wr_ready,
  output logic       done
);
  localparam int PWR_CYC = PWRUP_US * CYC_PER_US;
  localparam int RST_CYC = POSTRST_US * CYC_PER_US;
  localparam int CAL_CYC = CAL_US * CYC_PER_US;
  localparam int MAX_A   = (PWR_CYC > RST_CYC) ? PWR_CYC : RST_CYC;
  localparam int MAX_B   = (MAX_A > CAL_CYC) ? MAX_A : CAL_CYC;
  localparam int MAX_CYC = (MAX_B > RST_PULSE_CYC) ? MAX_B : RST_PULSE_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);

  state_e         state;
  logic [PCW-1:0] pc;
  logic           ilv_q;
  entry_t         cur;
  logic           tmr_load;
  logic [TW-1:0]  tmr_val;
  logic           tmr_zero;

  cfg_seq_rom u_rom (.pc(pc), .entry(cur));

  cfg_seq_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  always_comb begin
    tmr_load = (state == S_EXEC) && (cur.op == OP_WAIT || cur.op == OP_PULSE);
    if (cur.op == OP_PULSE)          tmr_val = TW'(RST_PULSE_CYC);
    else if (cur.addr == WSEL_PWR)   tmr_val = TW'(PWR_CYC);
    else if (cur.addr == WSEL_RST)   tmr_val = TW'(RST_CYC);
    else                             tmr_val = TW'(CAL_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pc         <= '0;
      ilv_q      <= 1'b0;
      conv_reset <= 1'b0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      done       <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pc    <= '0;
          ilv_q <= interleave;
          done  <= 1'b0;
          state <= S_EXEC;
        end
        S_EXEC: begin
          case (cur.op)
            OP_WR, OP_WRI: begin
              if (cur.op == OP_WRI && !ilv_q) begin
                pc <= pc + 1'b1;
              end else begin
                wr_valid <= 1'b1;
                wr_addr  <= cur.addr;
                wr_data  <= ilv_q ? cur.d_ilv : cur.d_plain;
                state    <= S_WR;
              end
            end
            OP_WAIT:  state <= S_WAIT;
            OP_PULSE: begin
              conv_reset <= 1'b1;
              state      <= S_PULSE;
            end
            default: begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          endcase
        end
        S_WR: if (wr_ready) begin
          wr_valid <= 1'b0;
          pc       <= pc + 1'b1;
          state    <= S_EXEC;
        end
        S_WAIT: if (tmr_zero) begin
          pc    <= pc + 1'b1;
          state <= S_EXEC;
        end
        S_PULSE: if (tmr_zero) begin
          conv_reset <= 1'b0;
          pc         <= pc + 1'b1;
          state      <= S_EXEC;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       conv_reset,
  input logic       wr_valid,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       wr_ready,
  input logic       done
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R7
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_valid); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    conv_reset |-> !wr_valid); // R2
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid && !conv_reset); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R8
endmodule

bind cfg_seq_top cfg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .conv_reset(conv_reset),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_ready(wr_ready), .done(done)
);

// File: tb/cfg_seq_top_tb.sv
module cfg_seq_top_tb;
  localparam int CPU = 2, PWR = 10, PRS = 5, CAL = 20, PUL = 3;
  localparam int N_PWR = PWR * CPU, N_PRS = PRS * CPU, N_CAL = CAL * CPU;

  logic clk = 0, rst_n = 0, start = 0, interleave = 0, wr_ready = 0;
  logic conv_reset, wr_valid, done;
  logic [7:0] wr_addr, wr_data;

  cfg_seq_top #(.CYC_PER_US(CPU), .PWRUP_US(PWR), .POSTRST_US(PRS),
                .CAL_US(CAL), .RST_PULSE_CYC(PUL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .interleave(interleave),
    .conv_reset(conv_reset), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .done(done));

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, errors = 0;
  int cyc = 0, rec_n = 0, rise_c = 0, fall_c = 0, stab_err = 0, start_c = 0;
  int dly = 0, dsel = 0;
  logic [7:0] rec_a [64]; logic [7:0] rec_d [64];
  int acc_c [64]; int fv_c [64];
  logic [7:0] exp_a [64]; logic [7:0] exp_d [64];
  int exp_n = 0, cal_i = 0;
  logic p_rst = 0, p_val = 0, p_rdy = 0; logic [7:0] p_a = 0, p_d = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual %0d expected %0d", req, act, expv); end
  endtask

  task automatic e(input logic [7:0] a, input logic [7:0] d);
    exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic pg(input logic [7:0] x, input logic [7:0] y, input logic [7:0] z);
    e(8'h11, x); e(8'h12, y); e(8'h13, z);
  endtask

  task automatic build(input bit ilv);
    exp_n = 0;
    e(8'h00, 8'h81);
    pg(8'h00, 8'h01, 8'h00);
    if (ilv) begin e(8'hA5, 8'h03); e(8'hA6, 8'h20); end
    e(8'hAB, ilv ? 8'h03 : 8'h01); e(8'hAC, ilv ? 8'h03 : 8'h01);
    e(8'hAD, 8'h08); e(8'hAE, 8'h08); e(8'h64, 8'h02);
    pg(8'h00, 8'h60, 8'h00); e(8'h26, 8'h0F); e(8'h20, 8'h80);
    pg(8'hFF, 8'h00, 8'h00); cal_i = exp_n; e(8'hD5, 8'h08);
    e(8'hD5, 8'h00); e(8'h2A, 8'h00); e(8'hCF, 8'h50);
    pg(8'h00, 8'h1E, 8'h00); e(8'h2D, 8'h02);
    pg(8'h00, 8'h01, 8'h00); e(8'h8C, 8'h02); e(8'hB7, 8'h01); e(8'hB7, 8'h00);
    pg(8'h00, 8'h00, 8'h01); e(8'h6A, 8'h02);
  endtask

  task automatic pulse_start(input bit ilv);
    @(negedge clk); start = 1; interleave = ilv; start_c = cyc + 1;
    @(negedge clk); start = 0; interleave = ~ilv;
  endtask

  task automatic run(input bit ilv, input bit poke, input string rq);
    int t;
    build(ilv);
    rec_n = 0; rise_c = 0; fall_c = 0; stab_err = 0;
    pulse_start(ilv);
    chk(done == 0, "R8 done clears on start", int'(done), 0);
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk); t++;
      if (poke && rec_n == 5 && !start) begin start = 1; interleave = ~ilv; end
      else start = 0;
    end
    start = 0;
    chk(t < 5000, "watchdog", t, 5000);
    chk(rise_c - start_c >= N_PWR && rise_c - start_c <= N_PWR + 4, "R2 power-on delay", rise_c - start_c, N_PWR);
    chk(fall_c - rise_c >= PUL && fall_c - rise_c <= PUL + 2, "R2 reset width", fall_c - rise_c, PUL);
    chk(fv_c[0] - fall_c >= N_PRS && fv_c[0] - fall_c <= N_PRS + 4, "R3 post-reset gap", fv_c[0] - fall_c, N_PRS);
    chk(fv_c[cal_i + 1] - acc_c[cal_i] >= N_CAL && fv_c[cal_i + 1] - acc_c[cal_i] <= N_CAL + 6,
        "R6 calibration gap", fv_c[cal_i + 1] - acc_c[cal_i], N_CAL);
    chk(rec_n == exp_n, rq, rec_n, exp_n);
    for (int i = 0; i < exp_n; i++)
      chk(rec_a[i] == exp_a[i] && rec_d[i] == exp_d[i], rq,
          int'({rec_a[i], rec_d[i]}), int'({exp_a[i], exp_d[i]}));
    chk(stab_err == 0, "R7 request held under back-pressure", stab_err, 0);
    repeat (6) @(negedge clk);
    chk(done == 1 && !wr_valid && !conv_reset && rec_n == exp_n, "R8 done holds quietly",
        rec_n, exp_n);
  endtask

  initial begin
    fork
      forever begin
        @(negedge clk); cyc++;
        if (conv_reset && !p_rst) rise_c = cyc;
        if (!conv_reset && p_rst) fall_c = cyc;
        if (wr_valid && !p_val) fv_c[rec_n] = cyc;
        if (wr_valid && p_val && !p_rdy && (wr_addr != p_a || wr_data != p_d)) stab_err++;
        p_rdy = wr_ready;
        if (wr_valid && !wr_ready) begin
          if (dly == 0) begin
            rec_a[rec_n] = wr_addr; rec_d[rec_n] = wr_data; acc_c[rec_n] = cyc;
            rec_n++; wr_ready = 1; dsel = (dsel + 1) % 4; dly = dsel;
          end else dly--;
        end else wr_ready = 0;
        p_rst = conv_reset; p_val = wr_valid; p_a = wr_addr; p_d = wr_data;
      end
    join_none
    repeat (3) @(negedge clk);
    chk(!wr_valid && !conv_reset && !done, "R1 state in reset", int'({wr_valid, conv_reset, done}), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!wr_valid && !conv_reset && !done, "R1 idle after reset", int'({wr_valid, conv_reset, done}), 0);
    run(1'b0, 1'b0, "R4 plain write list");
    run(1'b1, 1'b1, "R5 R9 interleaved list, mid-run start ignored");
    run(1'b0, 1'b0, "R4 R8 plain rerun after done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule